// File: doc/BRIEF.md
# Gated Frame Burst Stream Bridge

This block links a frame buffer FIFO, whose read data appears one clock after the read strobe, to a streaming consumer that uses valid/ready handshaking with zero ready latency. It keeps the consumer idle while the buffer is still filling. A frame starts only when a processor-written enable bit is set and the buffer reports that it holds a complete frame. The frame then goes out as one burst of complex samples. Each sample is a 32-bit word with the real part in the upper half and the imaginary part in the lower half. The first word carries a start-of-packet flag and the last word carries an end-of-packet flag.

A two-entry skid buffer absorbs words that were already requested from the FIFO when the consumer drops ready. No word is lost or repeated, and full rate is kept while ready stays high. When the last word is accepted, the block captures the consumer's per-frame scaling exponent and clears the enable. It also raises a frame-done status bit. The processor reads and clears these bits over a small register port.

Top module: `frame_burst_bridge`

## Requirements
- R1: A frame is FRAME_LEN 32-bit words, real part in bits [31:16] and imaginary part in bits [15:0]. The words leave in FIFO order, each exactly once.
- R2: No FIFO read request (`buf_rd`) is issued while the enable bit (control register bit 0) is clear.
- R3: A burst starts only when `buf_full` is high and the enable is set. With the buffer not full, there is no read and `st_valid` stays low.
- R4: `st_sop` is high only with `st_valid` and only on word index 0. `st_eop` is high only with `st_valid` and only on index FRAME_LEN-1. Exactly one start-of-packet transfer happens per frame.
- R5: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_data`, `st_sop` and `st_eop` hold their values into the next cycle.
- R6: Read data is taken one cycle after `buf_rd`. Buffered words plus requests in flight never exceed two. With `st_ready` held high, the frame's last word is accepted FRAME_LEN-1 cycles after its first.
- R7: In the cycle after the end-of-packet word is accepted, the enable reads 0 and frame-done (control register bit 1) reads 1. This hardware update takes priority over a register write in the same cycle.
- R8: `frame_exp` is captured on the cycle the end-of-packet word is accepted. It is held at every other time and reads at register address 1, zero-extended.
- R9: A write to address 0 loads the enable from `csr_wdata[0]`, and `csr_wdata[1]`=1 clears frame-done. Writes to address 1 are ignored. `csr_rdata` returns the addressed register one cycle after `csr_addr` is presented.
- R10: Synchronous reset clears the word counters, the skid buffer, the enable, frame-done and the exponent register. As a result, `st_valid`, `buf_rd` and both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_full | input | 1 | FIFO holds a complete frame |
| buf_rd | output | 1 | FIFO read request |
| buf_rdata | input | 32 | FIFO read data, valid one cycle after `buf_rd` |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Consumer ready, zero latency |
| st_data | output | 32 | Stream word {real, imaginary} |
| st_sop | output | 1 | Start-of-packet marker |
| st_eop | output | 1 | End-of-packet marker |
| frame_exp | input | EXP_W | Per-frame exponent from the consumer |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register address (0 control/status, 1 exponent) |
| csr_wdata | input | 2 | Register write data |
| csr_rdata | output | 32 | Registered read data |

## Verification
The bench builds the bridge with FRAME_LEN=16 and EXP_W=5. This keeps every frame short, so several complete bursts can run back to back. Those bursts reach the end-of-packet, done, auto-clear and exponent-capture path, a mid-frame reset, and frames under pseudo-random backpressure. The two-entry skid depth is left at its default, so a stall right at start-of-packet shows exactly two reads outstanding. The same stall also shows the marker held for many cycles.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  // Register addresses
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_EXP  = 1'b1;
  // Control/status bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_DONE = 1;
  // Skid buffer depth needed to cover one cycle of read latency
  localparam int SKID_DEPTH = 2;
endpackage

// File: rtl/fbb_skid.sv
module fbb_skid #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rdata,
  input  logic              pop,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [OCC_W-1:0]  occ,
  output logic              inflight
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              push;

  assign push  = inflight;
  assign valid = (occ != '0);
  assign data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      occ      <= '0;
      inflight <= 1'b0;
    end else begin
      inflight <= rd_req;
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      occ <= occ + OCC_W'(push) - OCC_W'(pop);
    end
  end
endmodule

// File: rtl/fbb_frame_ctrl.sv
module fbb_frame_ctrl #(
  parameter int FRAME_LEN = 1024,
  parameter int DEPTH     = 2,
  localparam int CNT_W    = $clog2(FRAME_LEN + 1),
  localparam int OCC_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             buf_full,
  input  logic             pop,
  input  logic [OCC_W-1:0] occ,
  input  logic             inflight,
  output logic             rd_req,
  output logic [CNT_W-1:0] idx,
  output logic             frame_end
);
  logic             active;
  logic [CNT_W-1:0] req_cnt;
  logic [OCC_W:0]   committed;

  always_comb begin
    committed = {1'b0, occ} + (OCC_W + 1)'(inflight) - (OCC_W + 1)'(pop);
    rd_req    = active && enable && (req_cnt < CNT_W'(FRAME_LEN))
                && (committed < (OCC_W + 1)'(DEPTH));
    frame_end = pop && (idx == CNT_W'(FRAME_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      req_cnt <= '0;
      idx     <= '0;
    end else if (frame_end) begin
      active  <= 1'b0;
      req_cnt <= '0;
      idx     <= '0;
    end else begin
      if (!active && enable && buf_full) active <= 1'b1;
      if (rd_req) req_cnt <= req_cnt + 1'b1;
      if (pop)    idx     <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/fbb_regs.sv
module fbb_regs #(
  parameter int EXP_W = 6,
  parameter int CSR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_wr,
  input  logic             csr_addr,
  input  logic [1:0]       csr_wdata,
  input  logic             frame_end,
  input  logic [EXP_W-1:0] exp_in,
  output logic             en_q,
  output logic             done_q,
  output logic [EXP_W-1:0] exp_q,
  output logic [CSR_W-1:0] csr_rdata
);
  import fbb_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      done_q    <= 1'b0;
      exp_q     <= '0;
      csr_rdata <= '0;
    end else begin
      if (csr_wr && csr_addr == ADDR_CTRL) begin
        en_q <= csr_wdata[BIT_EN];
        if (csr_wdata[BIT_DONE]) done_q <= 1'b0;
      end
      // hardware completion wins over a same-cycle write
      if (frame_end) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
        exp_q  <= exp_in;
      end
      if (csr_addr == ADDR_CTRL)
        csr_rdata <= {{(CSR_W - 2){1'b0}}, done_q, en_q};
      else
        csr_rdata <= {{(CSR_W - EXP_W){1'b0}}, exp_q};
    end
  end
endmodule

// File: rtl/frame_burst_bridge.sv
module frame_burst_bridge #(
  parameter int FRAME_LEN = 1024,
  parameter int HALF_W    = 16,
  parameter int EXP_W     = 6,
  parameter int CSR_W     = 32,
  localparam int DATA_W   = 2 * HALF_W,
  localparam int DEPTH    = fbb_pkg::SKID_DEPTH,
  localparam int CNT_W    = $clog2(FRAME_LEN + 1),
  localparam int OCC_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_full,
  output logic              buf_rd,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [DATA_W-1:0] st_data,
  output logic              st_sop,
  output logic              st_eop,
  input  logic [EXP_W-1:0]  frame_exp,
  input  logic              csr_wr,
  input  logic              csr_addr,
  input  logic [1:0]        csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata
);
  logic             en_q, done_q;
  logic [EXP_W-1:0] exp_q;
  logic [OCC_W-1:0] skid_occ;
  logic             inflight;
  logic             pop;
  logic             frame_end;
  logic [CNT_W-1:0] idx;

  assign pop    = st_valid && st_ready;
  assign st_sop = st_valid && (idx == '0);
  assign st_eop = st_valid && (idx == CNT_W'(FRAME_LEN - 1));

  fbb_skid #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_skid (
    .clk(clk), .rst(rst), .rd_req(buf_rd), .rdata(buf_rdata), .pop(pop),
    .valid(st_valid), .data(st_data), .occ(skid_occ), .inflight(inflight)
  );

  fbb_frame_ctrl #(.FRAME_LEN(FRAME_LEN), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .enable(en_q), .buf_full(buf_full), .pop(pop),
    .occ(skid_occ), .inflight(inflight), .rd_req(buf_rd), .idx(idx),
    .frame_end(frame_end)
  );

  fbb_regs #(.EXP_W(EXP_W), .CSR_W(CSR_W)) u_regs (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .frame_end(frame_end), .exp_in(frame_exp),
    .en_q(en_q), .done_q(done_q), .exp_q(exp_q), .csr_rdata(csr_rdata)
  );
endmodule

// File: rtl/fbb_checker.sv
module fbb_checker #(
  parameter int DATA_W = 32,
  parameter int EXP_W  = 6,
  parameter int OCC_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              buf_rd,
  input logic              st_valid,
  input logic              st_ready,
  input logic [DATA_W-1:0] st_data,
  input logic              st_sop,
  input logic              st_eop,
  input logic              en_q,
  input logic              done_q,
  input logic [EXP_W-1:0]  exp_q,
  input logic [OCC_W-1:0]  skid_occ,
  input logic              inflight
);
  AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    buf_rd |-> en_q); // R2
  AST_MARK_QUAL: assert property (@(posedge clk) disable iff (rst)
    (st_sop || st_eop) |-> st_valid); // R4
  AST_SOP_ONCE: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && st_sop && !st_eop) |=> !st_sop); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)
      && $stable(st_sop) && $stable(st_eop))); // R5
  AST_SKID_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, skid_occ} + (OCC_W + 1)'(inflight)) <= (OCC_W + 1)'(2)); // R6
  AST_DONE_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && st_eop) |=> (done_q && !en_q)); // R7
  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(st_valid && st_ready && st_eop) |=> $stable(exp_q)); // R8
endmodule

bind frame_burst_bridge fbb_checker #(.DATA_W(DATA_W), .EXP_W(EXP_W), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .buf_rd(buf_rd), .st_valid(st_valid), .st_ready(st_ready),
  .st_data(st_data), .st_sop(st_sop), .st_eop(st_eop), .en_q(en_q),
  .done_q(done_q), .exp_q(exp_q), .skid_occ(skid_occ), .inflight(inflight)
);

// File: tb/frame_burst_bridge_tb.sv
`timescale 1ns/1ps
module frame_burst_bridge_tb;
  localparam int LEN   = 16;
  localparam int EXP_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             buf_full, buf_rd;
  logic [31:0]      buf_rdata;
  logic             st_valid, st_ready, st_sop, st_eop;
  logic [31:0]      st_data;
  logic [EXP_W-1:0] frame_exp;
  logic             csr_wr, csr_addr;
  logic [1:0]       csr_wdata;
  logic [31:0]      csr_rdata;

  frame_burst_bridge #(.FRAME_LEN(LEN), .EXP_W(EXP_W)) u_dut (
    .clk(clk), .rst(rst), .buf_full(buf_full), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data), .st_sop(st_sop),
    .st_eop(st_eop), .frame_exp(frame_exp), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // FIFO model: one cycle read latency
  logic [31:0] fmem [LEN];
  int  frd = 0;
  bit  loaded = 0, load_req = 0;
  int  overrun = 0;
  assign buf_full = loaded && (frd == 0);
  always @(posedge clk) begin
    if (load_req) frd <= 0;
    else if (buf_rd) begin
      if (frd >= LEN) overrun <= overrun + 1;
      else buf_rdata <= fmem[frd];
      frd <= frd + 1;
    end
  end

  // Consumer ready model
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (ready_mode)
      0: st_ready <= 1'b1;
      1: st_ready <= lfsr[0] | lfsr[3];
      default: st_ready <= 1'b0;
    endcase
  end

  // Stream monitor
  int cyc = 0, rx_idx = 0, mon_err = 0, words = 0, sops = 0, eops = 0;
  int t_sop = 0, t_eop = 0;
  bit prv_stall = 0;
  logic [31:0] prv_data;
  logic prv_sop, prv_eop;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      rx_idx = 0; prv_stall = 0;
    end else begin
      if (prv_stall && (!st_valid || st_data !== prv_data || st_sop !== prv_sop
                        || st_eop !== prv_eop)) mon_err++;
      if (st_valid && st_ready) begin
        if (st_data !== fmem[rx_idx]) mon_err++;
        if (st_sop !== (rx_idx == 0)) mon_err++;
        if (st_eop !== (rx_idx == LEN - 1)) mon_err++;
        if (st_sop) begin sops++; t_sop = cyc; end
        if (st_eop) begin eops++; t_eop = cyc; end
        words++;
        rx_idx = (rx_idx == LEN - 1) ? 0 : rx_idx + 1;
      end
      prv_stall = st_valid && !st_ready;
      prv_data = st_data; prv_sop = st_sop; prv_eop = st_eop;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic csr_write(logic a, logic [1:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic csr_read(logic a, output logic [31:0] d);
    @(negedge clk); csr_addr = a;
    @(negedge clk); d = csr_rdata;
  endtask

  task automatic load_frame(int seed);
    for (int i = 0; i < LEN; i++)
      fmem[i] = {16'(seed * 97 + i), 16'(~(seed + i * 5))};
    @(negedge clk); load_req = 1;
    @(negedge clk); load_req = 0; loaded = 1;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] st;
    ok = 0;
    for (int i = 0; i < 500 && !ok; i++) begin
      csr_read(1'b0, st);
      if (st[1]) ok = 1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    check("R10 valid after reset", 32'(st_valid), 0);
    check("R10 rd after reset", 32'(buf_rd), 0);
    csr_read(1'b0, d); check("R10 ctrl after reset", d, 0);
    csr_read(1'b1, d); check("R10 exp after reset", d, 0);
  endtask

  task automatic t_not_full();
    logic [31:0] d;
    int f0;
    f0 = frd;
    csr_write(1'b0, 2'b01);
    repeat (20) @(negedge clk);
    check("R3 no read while not full", 32'(frd - f0), 0);
    check("R3 no valid while not full", 32'(st_valid), 0);
    csr_read(1'b0, d); check("R9 enable readback", d, 1);
    csr_write(1'b1, 2'b00);
    csr_read(1'b0, d); check("R9 write to addr1 ignored", d, 1);
    csr_write(1'b0, 2'b00);
  endtask

  task automatic t_no_enable();
    load_frame(3);
    repeat (20) @(negedge clk);
    check("R2 no read without enable", 32'(frd), 0);
    check("R2 no valid without enable", 32'(st_valid), 0);
  endtask

  task automatic t_frame(int mode, logic [EXP_W-1:0] ev, int seed);
    logic [31:0] d;
    bit ok;
    int w0, s0, e0, m0;
    frame_exp = ev;
    if (seed != 3) load_frame(seed);
    ready_mode = mode;
    w0 = words; s0 = sops; e0 = eops; m0 = mon_err;
    csr_write(1'b0, 2'b01);
    wait_done(ok);
    frame_exp = ~ev;
    check("R7 frame completes", 32'(ok), 1);
    check("R1 word count", 32'(words - w0), LEN);
    check("R1 R5 order, markers, stall hold", 32'(mon_err - m0), 0);
    check("R4 one sop", 32'(sops - s0), 1);
    check("R4 one eop", 32'(eops - e0), 1);
    check("R6 no FIFO overrun", 32'(overrun), 0);
    if (mode == 0) check("R6 full throughput", 32'(t_eop - t_sop), LEN - 1);
    csr_read(1'b0, d); check("R7 done set, enable cleared", d, 2);
    repeat (3) @(negedge clk);
    csr_read(1'b1, d); check("R8 exponent held", d, 32'(ev));
  endtask

  task automatic t_stall_sop();
    bit ok;
    int s0, w0;
    load_frame(9);
    ready_mode = 2;
    s0 = sops; w0 = words;
    csr_write(1'b0, 2'b11);
    repeat (30) @(negedge clk);
    check("R5 valid held during stall", 32'(st_valid), 1);
    check("R4 sop held, not repeated", {31'(sops - s0), st_sop}, 1);
    check("R6 two words outstanding", 32'(frd), 2);
    ready_mode = 0;
    wait_done(ok);
    check("R4 single sop after stall", 32'(sops - s0), 1);
    check("R1 word count after stall", 32'(words - w0), LEN);
  endtask

  task automatic t_clear_done();
    logic [31:0] d;
    csr_write(1'b0, 2'b10);
    csr_read(1'b0, d); check("R9 done cleared by write", d, 0);
  endtask

  task automatic t_mid_reset();
    logic [31:0] d;
    load_frame(21);
    ready_mode = 2;
    csr_write(1'b0, 2'b01);
    repeat (10) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    check("R10 valid cleared", 32'(st_valid), 0);
    csr_read(1'b0, d); check("R10 ctrl cleared", d, 0);
    csr_read(1'b1, d); check("R10 exp cleared", d, 0);
    ready_mode = 0;
  endtask

  initial begin
    csr_wr = 0; csr_addr = 0; csr_wdata = 0; frame_exp = '0; st_ready = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_not_full();
    t_no_enable();
    t_frame(0, 5'h13, 3);
    t_clear_done();
    t_frame(1, 5'h0A, 7);
    t_stall_sop();
    t_clear_done();
    t_mid_reset();
    t_frame(1, 5'h1E, 11);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule